// File: doc/BRIEF.md
# UART Register and FIFO Controller

This block is the bus-facing half of a UART. It keeps a control word and a status word, buffers outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO, and drives one active-high interrupt line. Software uses a 32-bit register interface with four word offsets: control at 0x0, receive data at 0x4, transmit data at 0x8 and status at 0xC. On the line side, a serialiser takes bytes from the transmit FIFO through a valid/ready handshake. A deserialiser offers received bytes, each with a line-error flag, through a valid/ready handshake as well.

The status word reports FIFO fill and error conditions, plus two pending bits that request service. Software clears the pending and error bits by writing one to them. A single level field in the status word shows the occupancy of one FIFO, and a control bit selects which one. Three more control bits turn on internal loopback, gate transmission on clear-to-send, and enable the whole block. Clearing the enable bit empties both FIFOs and parks the line side.

Top module: `uart_regfifo`

## Requirements
- R1: After reset the control word reads 0 and the status word reads 0x4A0 when cts is 1 (RX empty bit 5, CTS bit 7, TX empty bit 10). Only control bits 12 and 14 to 20 are stored, so writing all ones reads back 0x001F_D000.
- R2: Each write to offset 0x8 pushes bits 7:0 into the TX FIFO. The serialiser receives the bytes in write order. When the FIFO holds TX_DEPTH bytes, status bit 6 reads 1, and a further write is dropped and sets status bit 3.
- R3: A read of offset 0x4 returns the oldest RX byte in bits 7:0, with zeros above, and removes it. A read of offset 0x4 while the RX FIFO is empty returns 0 and changes nothing.
- R4: A byte arriving while the RX FIFO holds RX_DEPTH bytes is dropped and sets status bit 2. An accepted byte flagged with rx_err sets status bit 4.
- R5: Status bits 16:11 show the TX FIFO count when control bit 14 is 1, and the RX FIFO count when control bit 14 is 0.
- R6: Writing a 1 to any of status bits 4:0 clears that bit, and writing a 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R7: While the block is enabled, RX pending (bit 0) is set whenever the RX FIFO is not empty. TX pending (bit 1) is set whenever the TX FIFO holds fewer than TX_DEPTH/2 bytes. Both bits stay set until cleared.
- R8: irq is 1 exactly while (bit 0 and control bit 18) or (bit 1 and control bit 19) holds.
- R9: While control bit 15 (enable) is 0, both FIFOs are held empty, tx_valid and rx_ready are 0, and TX data writes are ignored.
- R10: With control bit 20 (loopback) set, TX FIFO bytes move straight into the RX FIFO in order. In this mode tx_valid and rx_ready stay 0.
- R11: With control bit 12 (auto flow) set, no byte is offered on tx_valid while cts is 0. The rts output and status bit 8 are 1 only while the block is enabled and the RX FIFO is not full. Status bit 7 mirrors cts.
- R12: Status bit 17 (busy) is 1 while the TX FIFO is not empty or tx_busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request, active high |
| tx_data | output | 8 | Byte offered to the serialiser |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Serialiser accepts the byte |
| tx_busy | input | 1 | Serialiser is still shifting |
| rx_data | input | 8 | Byte from the deserialiser |
| rx_err | input | 1 | Line error on rx_data |
| rx_valid | input | 1 | rx_data is valid |
| rx_ready | output | 1 | Block accepts received bytes |
| cts | input | 1 | Clear-to-send from the far end |
| rts | output | 1 | Request-to-send to the far end |

## Verification
The hardest states to reach are the full FIFO edges. These are the dropped transmit write that sets bit 3 and the dropped received byte that sets bit 2. Each must occur while the other side cannot drain. The bench holds tx_ready low while it writes one byte past TX_DEPTH. It then feeds one byte past RX_DEPTH without reading. After that it releases the line so that the scoreboard checks that only the accepted bytes come out, in order. The enable flush is reached by queuing transmit bytes with tx_ready low and then clearing enable. Those bytes must never appear on the line.

// File: rtl/uart_regfifo.sv
module uart_regfifo #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        tx_busy,
  input  logic [7:0]  rx_data,
  input  logic        rx_err,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic        cts,
  output logic        rts
);
  localparam int TAW = $clog2(TX_DEPTH);
  localparam int RAW = $clog2(RX_DEPTH);
  localparam int TCW = TAW + 1;
  localparam int RCW = RAW + 1;
  localparam logic [31:0] CTL_MASK = 32'h001F_D000;

  logic [31:0] ctl;
  logic [7:0]  tx_mem [TX_DEPTH];
  logic [7:0]  rx_mem [RX_DEPTH];
  logic [TAW-1:0] tx_wp, tx_rp;
  logic [RAW-1:0] rx_wp, rx_rp;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic rxp, txp, ovr, txe, lerr;

  wire en   = ctl[15];
  wire afe  = ctl[12];
  wire sel  = ctl[14];
  wire lben = ctl[20];

  wire wr_ctl = reg_en & reg_we  & (reg_addr == 4'h0);
  wire rd_rx  = reg_en & ~reg_we & (reg_addr == 4'h4);
  wire wr_tx  = reg_en & reg_we  & (reg_addr == 4'h8);
  wire wr_st  = reg_en & reg_we  & (reg_addr == 4'hC);
  wire [4:0] clr = wr_st ? reg_wdata[4:0] : 5'd0;

  wire tx_nz   = (tx_cnt != '0);
  wire tx_full = (tx_cnt == TCW'(TX_DEPTH));
  wire rx_nz   = (rx_cnt != '0);
  wire rx_full = (rx_cnt == RCW'(RX_DEPTH));

  assign tx_data  = tx_mem[tx_rp];
  assign tx_valid = en & ~lben & tx_nz & (~afe | cts);
  assign rx_ready = en & ~lben;
  assign rts      = en & ~rx_full;

  wire lb_move = en & lben & tx_nz;
  wire tx_push = wr_tx & en & ~tx_full;
  wire tx_pop  = (tx_valid & tx_ready) | lb_move;

  wire       rx_in    = lben ? lb_move : (rx_valid & rx_ready);
  wire [7:0] rx_in_d  = lben ? tx_mem[tx_rp] : rx_data;
  wire       rx_in_e  = ~lben & rx_err;
  wire       rx_push  = rx_in & ~rx_full;
  wire       rx_pop   = rd_rx & rx_nz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl <= '0;
    else if (wr_ctl) ctl <= reg_wdata & CTL_MASK;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_in_d;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (!en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + TCW'(tx_push) - TCW'(tx_pop);
      rx_cnt <= rx_cnt + RCW'(rx_push) - RCW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxp <= 1'b0; txp <= 1'b0; ovr <= 1'b0; txe <= 1'b0; lerr <= 1'b0;
    end else begin
      rxp  <= (rxp  & ~clr[0]) | (en & rx_nz);
      txp  <= (txp  & ~clr[1]) | (en & (tx_cnt < TCW'(TX_DEPTH / 2)));
      ovr  <= (ovr  & ~clr[2]) | (rx_in & rx_full);
      txe  <= (txe  & ~clr[3]) | (wr_tx & en & tx_full);
      lerr <= (lerr & ~clr[4]) | (rx_push & rx_in_e);
    end

  wire [5:0]  level  = sel ? 6'(tx_cnt) : 6'(rx_cnt);
  wire        busy   = tx_busy | tx_nz;
  wire [31:0] status = {14'd0, busy, level, ~tx_nz, 1'b0, rts, cts,
                        tx_full, ~rx_nz, lerr, txe, ovr, txp, rxp};

  assign irq = (rxp & ctl[18]) | (txp & ctl[19]);

  always_comb
    case (reg_addr)
      4'h0:    reg_rdata = ctl;
      4'h4:    reg_rdata = rx_nz ? {24'd0, rx_mem[rx_rp]} : 32'd0;
      4'hC:    reg_rdata = status;
      default: reg_rdata = 32'd0;
    endcase

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_cnt == '0 && rx_cnt == '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= TCW'(TX_DEPTH)) && (rx_cnt <= RCW'(RX_DEPTH)));

  // R2
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && en && tx_full && !tx_pop) |=> (txe && tx_cnt == $past(tx_cnt)));

  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && en) |=> (rx_cnt == $past(rx_cnt) - RCW'(1)));

  // R4
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in && rx_full && !rx_pop) |=> (ovr && rx_cnt == $past(rx_cnt)));
endmodule

// File: tb/uart_regfifo_tb.sv
module uart_regfifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, tx_valid, rx_ready, rts;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0, tx_busy = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_err = 1'b0, rx_valid = 1'b0, cts = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [7:0] txq[$];
  logic [31:0] v;

  localparam logic [31:0] EN = 32'h8000, SEL = 32'h4000, AFE = 32'h1000,
                          RXIE = 32'h4_0000, TXIE = 32'h8_0000, LBEN = 32'h10_0000;

  always #5 clk = ~clk;

  uart_regfifo u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    wr(4'h8, {24'd0, b});
    txq.push_back(b);
  endtask

  task automatic feed(input logic [7:0] b, input logic e);
    @(negedge clk); rx_valid = 1; rx_data = b; rx_err = e;
    @(posedge clk); #1 rx_valid = 0; rx_err = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      if (tx_valid && tx_ready) begin
        if (txq.size() == 0) chk("R2 unexpected tx byte", {24'd0, tx_data}, 32'hxx);
        else chk("R2 tx order", {24'd0, tx_data}, {24'd0, txq.pop_front()});
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    rd(4'hC, v); chk("R1 reset status", v, 32'h4A0);
    rd(4'h0, v); chk("R1 reset ctl", v, 32'h0);
    chk("R9 disabled tx_valid", {31'd0, tx_valid}, 0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R1 ctl mask", v, 32'h001F_D000);
    wr(4'h0, 0); wr(4'hC, 32'h1F); idle(1);
    rd(4'hC, v); chk("R6 w1c all", v, 32'h4A0);

    wr(4'h0, EN | SEL);
    for (int i = 0; i < 5; i++) send(8'h40 + 8'(i));
    idle(1);
    rd(4'hC, v);
    chk("R5 tx level", (v >> 11) & 32'h3F, 5);
    chk("R7 tx pending", v & 32'h2, 32'h2);
    chk("R12 busy fifo", (v >> 17) & 1, 1);
    chk("R11 rts when room", (v >> 8) & 1, 1);
    wr(4'h0, EN);
    rd(4'hC, v); chk("R5 rx level", (v >> 11) & 32'h3F, 0);

    for (int i = 5; i < 16; i++) send(8'h40 + 8'(i));
    rd(4'hC, v);
    chk("R2 full bit", (v >> 6) & 1, 1);
    chk("R2 no err yet", (v >> 3) & 1, 0);
    wr(4'h8, 32'hEE);
    rd(4'hC, v); chk("R2 drop err", (v >> 3) & 1, 1);
    wr(4'hC, 32'h0);
    rd(4'hC, v); chk("R6 zero keeps", (v >> 3) & 1, 1);
    wr(4'hC, 32'h8);
    rd(4'hC, v); chk("R6 one clears", (v >> 3) & 1, 0);
    @(negedge clk); tx_ready = 1;
    idle(24);
    chk("R2 drained", txq.size(), 0);
    rd(4'hC, v); chk("R2 tx empty bit", (v >> 10) & 1, 1);
    wr(4'h0, EN | TXIE); idle(1);
    chk("R8 irq tx", {31'd0, irq}, 1);
    wr(4'h0, EN); idle(1);
    chk("R8 irq masked", {31'd0, irq}, 0);

    wr(4'h0, EN | AFE);
    @(negedge clk); cts = 0;
    send(8'h77); send(8'h78); idle(5);
    chk("R11 gated by cts", {31'd0, tx_valid}, 0);
    rd(4'hC, v); chk("R11 cts bit", (v >> 7) & 1, 0);
    @(negedge clk); cts = 1;
    idle(6);
    chk("R11 sent after cts", txq.size(), 0);

    wr(4'h0, EN | RXIE);
    chk("R9 rx_ready enabled", {31'd0, rx_ready}, 1);
    feed(8'hA5, 0); feed(8'h3C, 0); feed(8'h81, 0); idle(2);
    chk("R8 irq rx", {31'd0, irq}, 1);
    rd(4'hC, v);
    chk("R7 rx pending", v & 1, 1);
    chk("R5 rx level 3", (v >> 11) & 32'h3F, 3);
    rd(4'h4, v); chk("R3 rx byte0", v, 32'hA5);
    rd(4'h4, v); chk("R3 rx byte1", v, 32'h3C);
    rd(4'h4, v); chk("R3 rx byte2", v, 32'h81);
    rd(4'h4, v); chk("R3 empty read", v, 0);
    rd(4'hC, v);
    chk("R3 level after empty read", (v >> 11) & 32'h3F, 0);
    chk("R7 rx pending sticky", v & 1, 1);
    wr(4'hC, 32'h1); idle(1);
    rd(4'hC, v); chk("R6 rx pending cleared", v & 1, 0);
    chk("R8 irq cleared", {31'd0, irq}, 0);

    feed(8'h5A, 1); idle(1);
    rd(4'hC, v); chk("R4 line err", (v >> 4) & 1, 1);
    rd(4'h4, v); chk("R4 err byte data", v, 32'h5A);
    wr(4'hC, 32'h10);
    for (int i = 0; i < 17; i++) feed(8'(i + 1), 0);
    idle(1);
    rd(4'hC, v);
    chk("R4 overrun", (v >> 2) & 1, 1);
    chk("R11 rts full bit", (v >> 8) & 1, 0);
    chk("R11 rts port", {31'd0, rts}, 0);
    chk("R4 level full", (v >> 11) & 32'h3F, 16);
    rd(4'h4, v); chk("R4 oldest kept", v, 32'h1);

    @(negedge clk); tx_ready = 0;
    wr(4'h8, 32'h99); wr(4'h8, 32'h9A);
    wr(4'h0, 0); idle(2);
    rd(4'hC, v);
    chk("R9 rx flushed", (v >> 5) & 1, 1);
    chk("R9 tx flushed", (v >> 10) & 1, 1);
    chk("R9 rx_ready off", {31'd0, rx_ready}, 0);
    wr(4'h8, 32'h9B);
    @(negedge clk); tx_ready = 1;
    wr(4'h0, EN); idle(3);
    chk("R9 nothing sent", {31'd0, tx_valid}, 0);

    wr(4'h0, EN | LBEN);
    wr(4'h8, 32'h11); wr(4'h8, 32'h22); idle(3);
    chk("R10 rx_ready off", {31'd0, rx_ready}, 0);
    chk("R10 tx_valid off", {31'd0, tx_valid}, 0);
    rd(4'hC, v); chk("R10 looped level", (v >> 11) & 32'h3F, 2);
    rd(4'h4, v); chk("R10 loop byte0", v, 32'h11);
    rd(4'h4, v); chk("R10 loop byte1", v, 32'h22);

    wr(4'h0, EN);
    @(negedge clk); tx_busy = 1;
    rd(4'hC, v); chk("R12 busy input", (v >> 17) & 1, 1);
    @(negedge clk); tx_busy = 0;
    rd(4'hC, v); chk("R12 idle", (v >> 17) & 1, 0);
    chk("R2 scoreboard empty", txq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule